// File: doc/BRIEF.md
# Iterative Lowest-Flag Cluster Extractor

This block takes a wide vector of cluster-start flags, one flag per pad, together with a 3-bit size for every pad. It turns that vector into a short list of the lowest-addressed clusters. A load strobe captures both inputs into working registers. On every following fast-clock cycle, the lowest set flag in the working copy is cleared. In the same cycle, a segmented priority encoder reports the address of that flag and the size stored for that pad.

The slot list fills in ascending address order, one slot per cycle. Slots that find no flag receive an all-ones address that no pad can have. A one-cycle completion pulse marks the moment the last slot has been written. Clearing never waits on the encoder. The next working value depends only on the current one, because the lowest bit of each segment is isolated with a two's-complement mask and a prefix OR across segments.

Two such extractors, each working on one half of a larger detector vector, can be used side by side. A separate merge stage then combines their sorted lists.

Top module: `cluster_extract`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, `done` is low and every slot address reads all ones (0x7FF for an 11-bit address).
- R2: A high `load` sampled on a clock edge captures `flags_in` and `sizes_in`. Later changes on those inputs have no effect on the slot list of that load.
- R3: Slot k holds the address of the (k+1)-th lowest set flag, so valid addresses rise strictly with slot index. Slot k sits in bits [k*ADDR_W +: ADDR_W] of `slot_addr`.
- R4: Each slot with a valid address holds, in bits [k*SIZE_W +: SIZE_W] of `slot_size`, the size given for that pad in `sizes_in[pad*SIZE_W +: SIZE_W]` at load time.
- R5: When fewer than NSLOT flags are set, every unused slot holds address all ones and size zero, and no unused slot comes before a used one.
- R6: When more than NSLOT flags are set, only the NSLOT lowest addresses are reported.
- R7: `done` is high for exactly one cycle: the cycle after the (NSLOT+1)-th clock edge that follows the edge sampling `load`. All slots are final in that cycle.
- R8: A `load` arriving while an extraction is in progress abandons it. No `done` is given for the abandoned vector, and the new vector is timed from the new load as in R7.
- R9: Flags at segment edges (pad 0, the last pad, and the last or first pad of neighbouring segments) are found in the correct order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture strobe for a new flag vector |
| flags_in | input | NPADS | One cluster-start flag per pad |
| sizes_in | input | NPADS*SIZE_W | Cluster size per pad, pad p at [p*SIZE_W +: SIZE_W] |
| slot_addr | output | NSLOT*ADDR_W | Packed list of slot addresses |
| slot_size | output | NSLOT*SIZE_W | Packed list of slot sizes |
| done | output | 1 | One-cycle pulse when all slots are written |

## Verification
The load edge is counted as edge zero. Every slot result is final one cycle after edge NSLOT+1, which is the cycle in which `done` is high. The bench drives and samples on falling edges. It confirms `done` is low on each of the eight falling edges after the load is released and high on the ninth, and checks the whole slot list against a bench-computed scan in that same cycle. It then confirms on the next falling edge that the pulse has ended. For a restarted load, the same count begins at the second strobe. The low `done` values seen in between are what show that the abandoned vector gave no pulse.

// File: rtl/cxt_pkg.sv
package cxt_pkg;
   typedef enum logic [0:0] {
      CXT_IDLE = 1'b0,
      CXT_SCAN = 1'b1
   } cxt_state_e;
endpackage

// File: rtl/cxt_seg_trunc.sv
module cxt_seg_trunc #(
   parameter int NPADS = 768,
   parameter int SEG_W = 64
) (
   input  logic [NPADS-1:0] work_i,
   output logic [NPADS-1:0] next_o
);
   localparam int NSEG = NPADS / SEG_W;

   logic [NSEG:0] lower_busy;
   assign lower_busy[0] = 1'b0;

   for (genvar s = 0; s < NSEG; s++) begin : g_seg
      logic [SEG_W-1:0] seg;
      logic [SEG_W-1:0] lowest;
      logic [SEG_W-1:0] cleared;
      assign seg     = work_i[s*SEG_W +: SEG_W];
      assign lowest  = seg & (~seg + SEG_W'(1));
      assign cleared = seg & ~lowest;
      assign lower_busy[s+1] = lower_busy[s] | (|seg);
      if (s == 0) begin : g_first
         assign next_o[s*SEG_W +: SEG_W] = cleared;
      end else begin : g_rest
         assign next_o[s*SEG_W +: SEG_W] = lower_busy[s] ? seg : cleared;
      end
   end
endmodule

// File: rtl/cxt_lsb_enc.sv
module cxt_lsb_enc #(
   parameter int NPADS  = 768,
   parameter int SEG_W  = 64,
   parameter int ADDR_W = 11
) (
   input  logic [NPADS-1:0]  vec_i,
   output logic              found_o,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int NSEG  = NPADS / SEG_W;
   localparam int LOC_W = (SEG_W > 1) ? $clog2(SEG_W) : 1;

   logic [NSEG-1:0] seg_any;
   logic [LOC_W-1:0] seg_loc [NSEG];

   for (genvar s = 0; s < NSEG; s++) begin : g_seg
      always_comb begin
         seg_any[s] = |vec_i[s*SEG_W +: SEG_W];
         seg_loc[s] = '0;
         for (int b = SEG_W - 1; b >= 0; b--) begin
            if (vec_i[s*SEG_W + b]) seg_loc[s] = LOC_W'(b);
         end
      end
   end

   always_comb begin
      found_o = 1'b0;
      addr_o  = '0;
      for (int s = NSEG - 1; s >= 0; s--) begin
         if (seg_any[s]) begin
            found_o = 1'b1;
            addr_o  = ADDR_W'(s * SEG_W) + ADDR_W'(seg_loc[s]);
         end
      end
   end
endmodule

// File: rtl/cxt_size_sel.sv
module cxt_size_sel #(
   parameter int NPADS  = 768,
   parameter int SIZE_W = 3,
   parameter int ADDR_W = 11
) (
   input  logic [NPADS*SIZE_W-1:0] sizes_i,
   input  logic                    found_i,
   input  logic [ADDR_W-1:0]       addr_i,
   output logic [SIZE_W-1:0]       size_o
);
   always_comb begin
      size_o = '0;
      if (found_i && (int'(addr_i) < NPADS)) begin
         size_o = sizes_i[int'(addr_i)*SIZE_W +: SIZE_W];
      end
   end
endmodule

// File: rtl/cluster_extract.sv
module cluster_extract
   import cxt_pkg::*;
#(
   parameter int NPADS  = 768,
   parameter int SEG_W  = 64,
   parameter int NSLOT  = 8,
   parameter int ADDR_W = 11,
   parameter int SIZE_W = 3
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    load,
   input  logic [NPADS-1:0]        flags_in,
   input  logic [NPADS*SIZE_W-1:0] sizes_in,
   output logic [NSLOT*ADDR_W-1:0] slot_addr,
   output logic [NSLOT*SIZE_W-1:0] slot_size,
   output logic                    done
);
   localparam int STEP_W = $clog2(NSLOT);
   localparam logic [ADDR_W-1:0] NO_ADDR = {ADDR_W{1'b1}};
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NSLOT - 1);

   if (NPADS % SEG_W != 0) begin : g_err_seg
      $error("NPADS must be a multiple of SEG_W");
   end
   if (NPADS > (1 << ADDR_W) - 1) begin : g_err_addr
      $error("ADDR_W too narrow to keep an unused all-ones address");
   end
   if (NSLOT < 2) begin : g_err_slot
      $error("NSLOT must be at least 2");
   end
   if (SIZE_W < 1) begin : g_err_size
      $error("SIZE_W must be at least 1");
   end

   cxt_state_e                state_q;
   logic [NPADS-1:0]          work_q;
   logic [NPADS-1:0]          work_next;
   logic [NPADS*SIZE_W-1:0]   sizes_q;
   logic [STEP_W-1:0]         step_q;
   logic                      enc_vld_q;
   logic [STEP_W-1:0]         enc_idx_q;
   logic [ADDR_W-1:0]         enc_addr_q;
   logic [SIZE_W-1:0]         enc_size_q;
   logic                      enc_found;
   logic [ADDR_W-1:0]         enc_addr;
   logic [SIZE_W-1:0]         enc_size;
   logic [ADDR_W-1:0]         addr_q [NSLOT];
   logic [SIZE_W-1:0]         size_q [NSLOT];
   logic                      done_q;

   cxt_seg_trunc #(.NPADS(NPADS), .SEG_W(SEG_W)) i_trunc (
      .work_i (work_q),
      .next_o (work_next)
   );

   cxt_lsb_enc #(.NPADS(NPADS), .SEG_W(SEG_W), .ADDR_W(ADDR_W)) i_enc (
      .vec_i   (work_q),
      .found_o (enc_found),
      .addr_o  (enc_addr)
   );

   cxt_size_sel #(.NPADS(NPADS), .SIZE_W(SIZE_W), .ADDR_W(ADDR_W)) i_size (
      .sizes_i (sizes_q),
      .found_i (enc_found),
      .addr_i  (enc_addr),
      .size_o  (enc_size)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q    <= CXT_IDLE;
         work_q     <= '0;
         sizes_q    <= '0;
         step_q     <= '0;
         enc_vld_q  <= 1'b0;
         enc_idx_q  <= '0;
         enc_addr_q <= NO_ADDR;
         enc_size_q <= '0;
      end else if (load) begin
         state_q   <= CXT_SCAN;
         work_q    <= flags_in;
         sizes_q   <= sizes_in;
         step_q    <= '0;
         enc_vld_q <= 1'b0;
      end else if (state_q == CXT_SCAN) begin
         work_q     <= work_next;
         enc_vld_q  <= 1'b1;
         enc_idx_q  <= step_q;
         enc_addr_q <= enc_found ? enc_addr : NO_ADDR;
         enc_size_q <= enc_found ? enc_size : '0;
         step_q     <= step_q + STEP_W'(1);
         if (step_q == LAST_STEP) state_q <= CXT_IDLE;
      end else begin
         enc_vld_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         done_q <= 1'b0;
      end else begin
         done_q <= enc_vld_q && !load && (enc_idx_q == LAST_STEP);
      end
   end

   for (genvar k = 0; k < NSLOT; k++) begin : g_slot
      always_ff @(posedge clk) begin
         if (rst) begin
            addr_q[k] <= NO_ADDR;
            size_q[k] <= '0;
         end else if (enc_vld_q && !load && (enc_idx_q == STEP_W'(k))) begin
            addr_q[k] <= enc_addr_q;
            size_q[k] <= enc_size_q;
         end
      end
      assign slot_addr[k*ADDR_W +: ADDR_W] = addr_q[k];
      assign slot_size[k*SIZE_W +: SIZE_W] = size_q[k];
   end

   assign done = done_q;
endmodule

// File: rtl/cluster_extract_chk.sv
module cluster_extract_chk #(
   parameter int NPADS  = 768,
   parameter int NSLOT  = 8,
   parameter int ADDR_W = 11
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    load,
   input logic [NSLOT*ADDR_W-1:0] slot_addr,
   input logic                    done
);
   localparam logic [ADDR_W-1:0] NO_ADDR = {ADDR_W{1'b1}};

   logic        armed_q;
   logic [15:0] since_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         armed_q <= 1'b0;
         since_q <= '0;
      end else if (load) begin
         armed_q <= 1'b1;
         since_q <= '0;
      end else if (armed_q && since_q != 16'hFFFF) begin
         since_q <= since_q + 16'd1;
      end
   end

   a_r1_reset_idle: assert property (@(posedge clk) rst |=> !done);

   a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   a_r7_done_latency: assert property (@(posedge clk) disable iff (rst)
      done |-> (armed_q && since_q == 16'(NSLOT + 1)));

   for (genvar k = 0; k < NSLOT; k++) begin : g_rng
      a_r3_addr_range: assert property (@(posedge clk) disable iff (rst)
         (slot_addr[k*ADDR_W +: ADDR_W] == NO_ADDR) ||
         (int'(slot_addr[k*ADDR_W +: ADDR_W]) < NPADS));
   end

   for (genvar k = 0; k < NSLOT - 1; k++) begin : g_ord
      a_r3_ascending: assert property (@(posedge clk) disable iff (rst)
         done && (slot_addr[(k+1)*ADDR_W +: ADDR_W] != NO_ADDR) |->
         (slot_addr[k*ADDR_W +: ADDR_W] < slot_addr[(k+1)*ADDR_W +: ADDR_W]));
      a_r5_invalid_tail: assert property (@(posedge clk) disable iff (rst)
         done && (slot_addr[k*ADDR_W +: ADDR_W] == NO_ADDR) |->
         (slot_addr[(k+1)*ADDR_W +: ADDR_W] == NO_ADDR));
   end
endmodule

bind cluster_extract cluster_extract_chk #(
   .NPADS(NPADS), .NSLOT(NSLOT), .ADDR_W(ADDR_W)
) i_chk (
   .clk       (clk),
   .rst       (rst),
   .load      (load),
   .slot_addr (slot_addr),
   .done      (done)
);

// File: tb/test_cluster_extract.sv
`timescale 1ns/1ps
module test_cluster_extract;
   localparam int NPADS  = 768;
   localparam int SEG_W  = 64;
   localparam int NSLOT  = 8;
   localparam int ADDR_W = 11;
   localparam int SIZE_W = 3;
   localparam logic [ADDR_W-1:0] NO_ADDR = {ADDR_W{1'b1}};

   logic                    clk = 1'b0;
   logic                    rst = 1'b1;
   logic                    load = 1'b0;
   logic [NPADS-1:0]        flags_in = '0;
   logic [NPADS*SIZE_W-1:0] sizes_in = '0;
   logic [NSLOT*ADDR_W-1:0] slot_addr;
   logic [NSLOT*SIZE_W-1:0] slot_size;
   logic                    done;

   int checks = 0;
   int errors = 0;
   logic [ADDR_W-1:0] exp_addr [NSLOT];
   logic [SIZE_W-1:0] exp_size [NSLOT];

   always #5 clk = ~clk;

   cluster_extract #(
      .NPADS(NPADS), .SEG_W(SEG_W), .NSLOT(NSLOT),
      .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)
   ) i_cluster_extract (
      .clk(clk), .rst(rst), .load(load), .flags_in(flags_in),
      .sizes_in(sizes_in), .slot_addr(slot_addr), .slot_size(slot_size),
      .done(done)
   );

   task automatic check(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic model(input logic [NPADS-1:0] f, input logic [NPADS*SIZE_W-1:0] s);
      int n = 0;
      for (int k = 0; k < NSLOT; k++) begin
         exp_addr[k] = NO_ADDR;
         exp_size[k] = '0;
      end
      for (int p = 0; p < NPADS; p++) begin
         if (f[p] && n < NSLOT) begin
            exp_addr[n] = ADDR_W'(p);
            exp_size[n] = s[p*SIZE_W +: SIZE_W];
            n++;
         end
      end
   endtask

   function automatic logic [NPADS*SIZE_W-1:0] rand_sizes();
      logic [NPADS*SIZE_W-1:0] v;
      for (int w = 0; w < NPADS*SIZE_W; w += 32) v[w +: 32] = $urandom;
      return v;
   endfunction

   function automatic logic [NPADS-1:0] rand_flags(input int maxn);
      logic [NPADS-1:0] v = '0;
      int n = $urandom_range(0, maxn);
      for (int i = 0; i < n; i++) v[$urandom_range(0, NPADS-1)] = 1'b1;
      return v;
   endfunction

   task automatic start(input logic [NPADS-1:0] f, input logic [NPADS*SIZE_W-1:0] s);
      @(negedge clk);
      load = 1'b1; flags_in = f; sizes_in = s;
      model(f, s);
      @(negedge clk);
      load = 1'b0;
      // R2: scramble inputs after capture
      flags_in = rand_flags(40);
      sizes_in = rand_sizes();
   endtask

   task automatic finish(input string tag);
      for (int i = 0; i < NSLOT; i++) begin
         @(negedge clk);
         check(done == 1'b0, {"R7 early done ", tag}, int'(done), 0);
      end
      @(negedge clk);
      check(done == 1'b1, {"R7 done due ", tag}, int'(done), 1);
      for (int k = 0; k < NSLOT; k++) begin
         check(slot_addr[k*ADDR_W +: ADDR_W] == exp_addr[k], {"R3 R2 R6 address ", tag},
               int'(slot_addr[k*ADDR_W +: ADDR_W]), int'(exp_addr[k]));
         if (exp_addr[k] != NO_ADDR)
            check(slot_size[k*SIZE_W +: SIZE_W] == exp_size[k], {"R4 size ", tag},
                  int'(slot_size[k*SIZE_W +: SIZE_W]), int'(exp_size[k]));
         else
            check(slot_size[k*SIZE_W +: SIZE_W] == '0, {"R5 empty size ", tag},
                  int'(slot_size[k*SIZE_W +: SIZE_W]), 0);
      end
      @(negedge clk);
      check(done == 1'b0, {"R7 single pulse ", tag}, int'(done), 0);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [NPADS-1:0] f;
      logic [NPADS*SIZE_W-1:0] s;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check(done == 1'b0, "R1 done in reset", int'(done), 0);
      rst = 1'b0;
      @(negedge clk);
      for (int k = 0; k < NSLOT; k++)
         check(slot_addr[k*ADDR_W +: ADDR_W] == NO_ADDR, "R1 slot after reset",
               int'(slot_addr[k*ADDR_W +: ADDR_W]), int'(NO_ADDR));
      check(done == 1'b0, "R1 done after reset", int'(done), 0);

      // R5: empty vector
      start('0, rand_sizes()); finish("R5 empty");
      // R5: three flags
      f = '0; f[5] = 1; f[300] = 1; f[700] = 1;
      start(f, rand_sizes()); finish("R5 three");
      // R9: pad 0, last pad, segment neighbours
      f = '0; f[0] = 1; f[NPADS-1] = 1; f[63] = 1; f[64] = 1; f[127] = 1; f[128] = 1;
      start(f, rand_sizes()); finish("R9 edges");
      // R6: many flags, dense low segment
      f = '0; f[15:0] = '1; f[400] = 1;
      start(f, rand_sizes()); finish("R6 dense");
      // R6 R9: all flags set
      start('1, rand_sizes()); finish("R6 full");
      // R8: restart during scan
      f = '0; f[10] = 1; f[20] = 1;
      s = rand_sizes();
      start(f, s);
      repeat (2) begin
         @(negedge clk);
         check(done == 1'b0, "R8 no done before restart", int'(done), 0);
      end
      f = '0; f[33] = 1; f[500] = 1; f[501] = 1;
      start(f, rand_sizes()); finish("R8 restart");
      // R3 R4: random vectors
      for (int t = 0; t < 40; t++) begin
         start(rand_flags((t % 2) ? 20 : 6), rand_sizes());
         finish("R3 random");
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule